// File: doc/BRIEF.md
# ADC Serial-Port Power-Mode Tracker

This block models, on the device side, the power-mode logic of a two-channel serial ADC. It oversamples the active-low chip select and the serial clock with a fast system clock, counts serial-clock falling edges within each frame, and decides the next power mode from how many edges had arrived when chip select went high again. It reports the current mode, a data-valid flag for the frame in progress, and output-drive enables for the two serial data lines.

Ending a frame early, in a window of edge counts, steps the part down: normal goes to partial power-down, and partial goes to full power-down. A frame that starts while the part is powered down is a dummy frame that starts the wake-up. If that frame runs to at least the tenth edge, the part returns to normal once a wake delay has elapsed. The delay is a clock count, with separate counts for partial and full power-down. If the dummy frame is cut short, the part falls back to a power-down state. Frames that end very early are treated as glitches and change nothing. The conversion itself, the data bits and the reference circuitry are not modelled.

Both inputs pass through a two-stage synchronizer before edge detection, so the block reacts to an input change at the third rising clock edge after the change.

Top module: `pmt_power_tracker`

## Requirements
- R1: After reset, pwr_state is 2'b00 (normal), data_valid is 0 and both dout_oe bits are 0.
- R2: In normal mode, a chip-select rise after at least 2 and at most 9 serial-clock falling edges of the frame moves pwr_state to 2'b10 (partial power-down).
- R3: In normal mode, a chip-select rise after fewer than 2 falling edges leaves the mode at normal.
- R4: In normal mode, a chip-select rise after 10 or more falling edges leaves the mode at normal. This includes a rise detected in the same cycle as the tenth falling edge.
- R5: In partial (2'b10) or full (2'b11) power-down, a chip-select fall moves pwr_state to 2'b01 (powering up).
- R6: While powering up, a chip-select rise that ends the dummy frame before its 2nd falling edge returns the part to the power-down state it woke from.
- R7: While powering up, a chip-select rise that ends the dummy frame after 2 to 9 falling edges moves pwr_state to 2'b11 (full power-down).
- R8: A dummy frame that reaches 10 or more falling edges before chip select rises leads to normal mode. The change happens only after the wake delay has elapsed since the chip-select fall: PART_WAKE_CYC cycles from partial power-down, FULL_WAKE_CYC cycles from full power-down.
- R9: data_valid is 1 only while chip select is low in a frame that began in normal mode. It is 0 throughout a dummy frame and clears on the chip-select rise.
- R10: Both dout_oe bits go to 1 at a chip-select fall. They go to 0 at the chip-select rise or at the 16th falling edge, whichever comes first. After any power-down entry they are 0.
- R11: The edge count restarts at each chip-select fall and stops at 16. Further edges in the same frame do not re-enable the outputs or change the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial port |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the host, asynchronous |
| sclk | input | 1 | Serial clock from the host, asynchronous, idles high |
| pwr_state | output | 2 | 00 normal, 01 powering up, 10 partial power-down, 11 full power-down |
| data_valid | output | 1 | Frame in progress carries a valid conversion |
| dout_oe | output | CHANNELS | Drive enable per serial data line (0 = three-state) |

## Verification
The bench aims at both ends of the step-down window. It ends frames after exactly 2 edges and after exactly 9, and it raises chip select in the same cycle as the tenth edge. A design with an off-by-one window would power down on that tenth-edge rise, or fail to power down at 2 or 9. It ends dummy frames with no edges or one edge from both power-down states: a design that forgets where it woke from would land in the wrong state. It checks that the mode is still powering up after a long dummy frame from full power-down, which catches a wake timer that is ignored or loaded with the wrong count. It also sends a 20-edge frame, where a counter that wraps would turn the outputs back on.

// File: rtl/pmt_pkg.sv
// Package: shared types for the serial-port power-mode tracker.
// Assumes: the 2-bit state encoding is visible at the top-level ports.
package pmt_pkg;

    // Power mode encoding presented on pwr_state
    typedef enum logic [1:0] {
        PM_NORMAL  = 2'b00,
        PM_WAKING  = 2'b01,
        PM_PARTIAL = 2'b10,
        PM_FULL    = 2'b11
    } pm_state_t;

endpackage

// File: rtl/pmt_sync.sv
// Module: pmt_sync
// Brings WIDTH asynchronous inputs into the clk domain through a chain of
// STAGES flops. It also keeps the previous synchronized value so that the
// parent can detect edges. Assumes STAGES >= 2 and that the inputs idle at IDLE.
module pmt_sync #(
    parameter int unsigned          STAGES = 2,
    parameter int unsigned          WIDTH  = 2,
    parameter logic [WIDTH-1:0]     IDLE   = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] prev
);

    logic [WIDTH-1:0] chain [STAGES];

    // Shift the raw inputs through the synchronizer chain and keep one delayed copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain[i] <= IDLE;
            end
            prev <= IDLE;
        end else begin
            chain[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
            prev <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];

endmodule

// File: rtl/pmt_edge_counter.sv
// Module: pmt_edge_counter
// Counts serial-clock falling edges inside a frame. The count clears at the
// chip-select fall and saturates at FRAME_EDGES. frame_edges gives the count
// including an edge seen in the current cycle, so a chip-select rise that
// coincides with an edge is classified after that edge. last_edge pulses on the
// edge that completes the frame.
// Assumes: cs_fall and sclk_fall are single-cycle pulses in the clk domain.
module pmt_edge_counter #(
    parameter int unsigned FRAME_EDGES = 16,
    localparam int unsigned CNT_W      = $clog2(FRAME_EDGES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_low,
    input  logic             cs_fall,
    input  logic             sclk_fall,
    output logic [CNT_W-1:0] frame_edges,
    output logic             last_edge
);

    localparam logic [CNT_W-1:0] CAP     = CNT_W'(FRAME_EDGES);
    localparam logic [CNT_W-1:0] CAP_M1  = CNT_W'(FRAME_EDGES - 1);

    logic [CNT_W-1:0] count;
    logic             room;

    assign room = (count < CAP);

    // Restart at the frame start, then count edges while chip select is low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (cs_fall) begin
            count <= '0;
        end else if (sclk_fall && cs_low && room) begin
            count <= count + 1'b1;
        end
    end

    // Edge total as seen at this cycle, counting a coincident edge
    always_comb begin
        frame_edges = count;
        if (sclk_fall && room) begin
            frame_edges = count + 1'b1;
        end
    end

    assign last_edge = sclk_fall && cs_low && (count == CAP_M1);

    assert_count_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (count == '0));

    assert_count_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CAP) && !cs_fall |=> (count == CAP));

endmodule

// File: rtl/pmt_power_fsm.sv
// Module: pmt_power_fsm
// Tracks the power mode. It classifies each chip-select rise by the edge
// total of the frame: below WIN_LO is a glitch, from WIN_LO up to but not
// including WIN_HI is a step-down request, and WIN_HI or more completes a frame.
// From a power-down state, a chip-select fall starts a wake-up with its own
// timer. Once the dummy frame has completed, the mode returns to normal after
// the timer expires.
// Assumes: cs_fall/cs_rise are single-cycle pulses and never coincide.
module pmt_power_fsm
    import pmt_pkg::*;
#(
    parameter int unsigned CNT_W         = 5,
    parameter int unsigned WIN_LO        = 2,
    parameter int unsigned WIN_HI        = 10,
    parameter int unsigned PART_WAKE_CYC = 40,
    parameter int unsigned FULL_WAKE_CYC = 500_000,
    localparam int unsigned WAKE_MAX     = (FULL_WAKE_CYC > PART_WAKE_CYC) ? FULL_WAKE_CYC : PART_WAKE_CYC,
    localparam int unsigned WAKE_W       = $clog2(WAKE_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_fall,
    input  logic             cs_rise,
    input  logic [CNT_W-1:0] frame_edges,
    output pm_state_t        state
);

    localparam logic [CNT_W-1:0]  LO_E    = CNT_W'(WIN_LO);
    localparam logic [CNT_W-1:0]  HI_E    = CNT_W'(WIN_HI);
    localparam logic [WAKE_W-1:0] PART_LD = WAKE_W'(PART_WAKE_CYC);
    localparam logic [WAKE_W-1:0] FULL_LD = WAKE_W'(FULL_WAKE_CYC);

    logic              from_full;
    logic              committed;
    logic [WAKE_W-1:0] wake_cnt;
    logic              too_short;
    logic              in_win;

    // Classify the frame total at the chip-select rise
    always_comb begin
        too_short = (frame_edges < LO_E);
        in_win    = !too_short && (frame_edges < HI_E);
    end

    // Mode transitions, wake-up origin and wake timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= PM_NORMAL;
            from_full <= 1'b0;
            committed <= 1'b0;
            wake_cnt  <= '0;
        end else begin
            case (state)
                PM_NORMAL: begin
                    if (cs_rise && in_win) begin
                        state <= PM_PARTIAL;
                    end
                end
                PM_PARTIAL: begin
                    if (cs_fall) begin
                        state     <= PM_WAKING;
                        from_full <= 1'b0;
                        committed <= 1'b0;
                        wake_cnt  <= PART_LD;
                    end
                end
                PM_FULL: begin
                    if (cs_fall) begin
                        state     <= PM_WAKING;
                        from_full <= 1'b1;
                        committed <= 1'b0;
                        wake_cnt  <= FULL_LD;
                    end
                end
                default: begin
                    if (wake_cnt != '0) begin
                        wake_cnt <= wake_cnt - 1'b1;
                    end
                    if (!committed) begin
                        if (cs_rise) begin
                            if (too_short) begin
                                state <= from_full ? PM_FULL : PM_PARTIAL;
                            end else if (in_win) begin
                                state <= PM_FULL;
                            end else begin
                                committed <= 1'b1;
                            end
                        end
                    end else if (wake_cnt == '0) begin
                        state <= PM_NORMAL;
                    end
                end
            endcase
        end
    end

    assert_step_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_NORMAL) && cs_rise && in_win |=> (state == PM_PARTIAL));

    assert_glitch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_NORMAL) && cs_rise && too_short |=> (state == PM_NORMAL));

    assert_wake_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == PM_PARTIAL) || (state == PM_FULL)) && cs_fall |=> (state == PM_WAKING));

    assert_fallback_partial_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_WAKING) && !committed && !from_full && cs_rise && too_short
        |=> (state == PM_PARTIAL));

    assert_no_early_normal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_WAKING) && (wake_cnt != '0) |=> (state != PM_NORMAL));

endmodule

// File: rtl/pmt_drive_ctrl.sv
// Module: pmt_drive_ctrl
// Generates the per-line output-drive enables and the data-valid flag.
// Drive starts at the chip-select fall. It stops at the rise or at the frame's
// last edge, whichever comes first. Data is valid only for frames that began
// in normal mode.
// Assumes: pulses are single-cycle, in_normal is the registered mode.
module pmt_drive_ctrl #(
    parameter int unsigned CHANNELS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_fall,
    input  logic                cs_rise,
    input  logic                last_edge,
    input  logic                in_normal,
    output logic [CHANNELS-1:0] dout_oe,
    output logic                data_valid
);

    // One drive-enable flop per data line
    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dout_oe[ch] <= 1'b0;
            end else if (cs_fall) begin
                dout_oe[ch] <= 1'b1;
            end else if (cs_rise || last_edge) begin
                dout_oe[ch] <= 1'b0;
            end
        end
    end

    // Mark the frame valid only when it opens in normal mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_valid <= 1'b0;
        end else if (cs_fall) begin
            data_valid <= in_normal;
        end else if (cs_rise) begin
            data_valid <= 1'b0;
        end
    end

    assert_oe_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> (dout_oe == '0));

    assert_oe_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (dout_oe == '1));

endmodule

// File: rtl/pmt_power_tracker.sv
// Module: pmt_power_tracker (top)
// Device-side model of a serial ADC's power-mode logic. It synchronizes chip
// select and serial clock, detects their edges, counts edges per frame,
// drives the power-mode state machine and the output-drive/valid flags.
// Assumes: clk is several times faster than sclk, and sclk idles high.
module pmt_power_tracker
    import pmt_pkg::*;
#(
    parameter int unsigned CHANNELS      = 2,
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned FRAME_EDGES   = 16,
    parameter int unsigned WIN_LO        = 2,
    parameter int unsigned WIN_HI        = 10,
    parameter int unsigned PART_WAKE_CYC = 40,
    parameter int unsigned FULL_WAKE_CYC = 500_000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                sclk,
    output logic [1:0]          pwr_state,
    output logic                data_valid,
    output logic [CHANNELS-1:0] dout_oe
);

    localparam int unsigned CNT_W = $clog2(FRAME_EDGES + 1);

    logic [1:0]       raw_in;
    logic [1:0]       sync_lvl;
    logic [1:0]       sync_prv;
    logic             cs_low;
    logic             cs_fall;
    logic             cs_rise;
    logic             sclk_fall;
    logic [CNT_W-1:0] frame_edges;
    logic             last_edge;
    pm_state_t        state;

    assign raw_in = {sclk, cs_n};

    pmt_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (2),
        .IDLE   (2'b11)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_in),
        .level (sync_lvl),
        .prev  (sync_prv)
    );

    // Edge pulses on the synchronized inputs
    always_comb begin
        cs_low    = !sync_lvl[0];
        cs_fall   = sync_prv[0] && !sync_lvl[0];
        cs_rise   = !sync_prv[0] && sync_lvl[0];
        sclk_fall = sync_prv[1] && !sync_lvl[1];
    end

    pmt_edge_counter #(
        .FRAME_EDGES (FRAME_EDGES)
    ) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_low      (cs_low),
        .cs_fall     (cs_fall),
        .sclk_fall   (sclk_fall),
        .frame_edges (frame_edges),
        .last_edge   (last_edge)
    );

    pmt_power_fsm #(
        .CNT_W         (CNT_W),
        .WIN_LO        (WIN_LO),
        .WIN_HI        (WIN_HI),
        .PART_WAKE_CYC (PART_WAKE_CYC),
        .FULL_WAKE_CYC (FULL_WAKE_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_fall     (cs_fall),
        .cs_rise     (cs_rise),
        .frame_edges (frame_edges),
        .state       (state)
    );

    pmt_drive_ctrl #(
        .CHANNELS (CHANNELS)
    ) u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_fall    (cs_fall),
        .cs_rise    (cs_rise),
        .last_edge  (last_edge),
        .in_normal  (state == PM_NORMAL),
        .dout_oe    (dout_oe),
        .data_valid (data_valid)
    );

    assign pwr_state = state;

    assert_valid_only_normal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> (state == PM_NORMAL));

    assert_down_tristate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == PM_PARTIAL) || (state == PM_FULL)) |-> (dout_oe == '0));

endmodule

// File: tb/pmt_power_tracker_bench.sv
// Bench for pmt_power_tracker. A behavioural reference model, written with
// integers and a sample queue, runs beside the design and is compared on
// every clock. Directed checks with hand-derived values are tagged by requirement.
module pmt_power_tracker_bench;

    localparam int PW = 40;
    localparam int FW = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b1;
    logic [1:0] pwr_state;
    logic       data_valid;
    logic [1:0] dout_oe;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    bit    live = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    pmt_power_tracker #(
        .PART_WAKE_CYC (PW),
        .FULL_WAKE_CYC (FW)
    ) u_pmt_power_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .pwr_state  (pwr_state),
        .data_valid (data_valid),
        .dout_oe    (dout_oe)
    );

    // Reference model state
    int csq[$];
    int scq[$];
    int m_state, m_cnt, m_wk;
    bit m_ff, m_cm, m_oe, m_dv;

    always @(posedge clk) begin
        if (!rst_n) begin
            csq = '{1, 1, 1};
            scq = '{1, 1, 1};
            m_state = 0; m_cnt = 0; m_wk = 0;
            m_ff = 0; m_cm = 0; m_oe = 0; m_dv = 0;
        end else begin
            int  os, n;
            bit  fall, rise, sf, low;
            os   = m_state;
            fall = (csq[0] == 1) && (csq[1] == 0);
            rise = (csq[0] == 0) && (csq[1] == 1);
            sf   = (scq[0] == 1) && (scq[1] == 0);
            low  = (csq[1] == 0);
            n    = m_cnt + ((sf && m_cnt < 16) ? 1 : 0);
            if (fall) m_dv = (os == 0);
            else if (rise) m_dv = 0;
            if (fall) m_oe = 1;
            else if (rise || (sf && low && m_cnt == 15)) m_oe = 0;
            case (os)
                0: if (rise && n >= 2 && n < 10) m_state = 2;
                2: if (fall) begin m_state = 1; m_ff = 0; m_cm = 0; m_wk = PW; end
                3: if (fall) begin m_state = 1; m_ff = 1; m_cm = 0; m_wk = FW; end
                default: begin
                    int nw;
                    nw = (m_wk > 0) ? m_wk - 1 : 0;
                    if (!m_cm) begin
                        if (rise) begin
                            if (n < 2) m_state = m_ff ? 3 : 2;
                            else if (n < 10) m_state = 3;
                            else m_cm = 1;
                        end
                    end else if (m_wk == 0) begin
                        m_state = 0;
                    end
                    m_wk = nw;
                end
            endcase
            if (fall) m_cnt = 0;
            else if (sf && low && m_cnt < 16) m_cnt = m_cnt + 1;
            csq.push_back(int'(cs_n)); void'(csq.pop_front());
            scq.push_back(int'(sclk)); void'(scq.pop_front());
        end
    end

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (live && !done) begin
            total++;
            if (pwr_state !== 2'(m_state) || data_valid !== m_dv || dout_oe !== {2{m_oe}}) begin
                bad++;
                $display("FAIL %s model: state=%0d dv=%0b oe=%b expected state=%0d dv=%0b oe=%b",
                         cur_req, pwr_state, data_valid, dout_oe, m_state, m_dv, {2{m_oe}});
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            sclk = 1'b0; tick(3);
            sclk = 1'b1; tick(3);
        end
    endtask

    task automatic frame(input int n);
        cs_n = 1'b0; tick(4);
        pulses(n);
        cs_n = 1'b1; tick(6);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(1);
        live = 1;
        cur_req = "R1";
        chk("R1 state", int'(pwr_state), 0);
        chk("R1 valid", int'(data_valid), 0);
        chk("R1 oe", int'(dout_oe), 0);
        tick(4);

        // Full normal frame: valid and drive, release at 16th edge
        cur_req = "R9";
        cs_n = 1'b0; tick(6);
        chk("R9 valid in normal frame", int'(data_valid), 1);
        chk("R10 oe open", int'(dout_oe), 3);
        pulses(16);
        chk("R10 oe off after 16th edge", int'(dout_oe), 0);
        cs_n = 1'b1; tick(6);
        chk("R4 complete frame stays normal", int'(pwr_state), 0);
        chk("R9 valid clears", int'(data_valid), 0);

        cur_req = "R3";
        frame(1);
        chk("R3 one-edge glitch", int'(pwr_state), 0);
        frame(0);
        chk("R3 zero-edge glitch", int'(pwr_state), 0);

        // Rise together with the 10th edge
        cur_req = "R4";
        cs_n = 1'b0; tick(4);
        pulses(9);
        sclk = 1'b0; cs_n = 1'b1; tick(3);
        sclk = 1'b1; tick(6);
        chk("R4 rise at 10th edge", int'(pwr_state), 0);

        cur_req = "R2";
        frame(2);
        chk("R2 two edges steps down", int'(pwr_state), 2);
        chk("R10 tristate after entry", int'(dout_oe), 0);

        cur_req = "R5";
        cs_n = 1'b0; tick(6);
        chk("R5 wake from partial", int'(pwr_state), 1);
        chk("R9 dummy frame invalid", int'(data_valid), 0);
        pulses(1);
        cs_n = 1'b1; tick(6);
        chk("R6 back to partial", int'(pwr_state), 2);

        cur_req = "R7";
        frame(9);
        chk("R7 partial to full at 9 edges", int'(pwr_state), 3);

        cur_req = "R6";
        cs_n = 1'b0; tick(6);
        chk("R5 wake from full", int'(pwr_state), 1);
        cs_n = 1'b1; tick(6);
        chk("R6 back to full", int'(pwr_state), 3);

        cur_req = "R7";
        frame(5);
        chk("R7 full stays full", int'(pwr_state), 3);

        cur_req = "R8";
        cs_n = 1'b0; tick(4);
        pulses(16);
        chk("R9 dummy frame still invalid", int'(data_valid), 0);
        cs_n = 1'b1; tick(6);
        chk("R8 not yet awake from full", int'(pwr_state), 1);
        tick(FW);
        chk("R8 awake from full", int'(pwr_state), 0);

        cur_req = "R9";
        cs_n = 1'b0; tick(6);
        chk("R9 valid after wake", int'(data_valid), 1);
        pulses(16);
        cs_n = 1'b1; tick(6);

        cur_req = "R8";
        frame(7);
        chk("R2 seven edges steps down", int'(pwr_state), 2);
        frame(12);
        chk("R8 awake from partial", int'(pwr_state), 0);

        cur_req = "R11";
        cs_n = 1'b0; tick(4);
        pulses(20);
        chk("R11 oe stays off past 16", int'(dout_oe), 0);
        cs_n = 1'b1; tick(6);
        chk("R11 saturated frame stays normal", int'(pwr_state), 0);

        cur_req = "R2";
        frame(9);
        chk("R2 nine edges steps down", int'(pwr_state), 2);

        tick(4);
        finish_run();
    end

endmodule